// File: doc/BRIEF.md
# I/O Interrupt Redirection Controller

This block converts a bank of external interrupt lines into vectored interrupt messages addressed to processors. Each line has its own redirection entry. The entry holds the vector, the delivery mode, the destination, the polarity, the trigger mode and a mask. Software reaches every register indirectly. It writes a register index into a select slot, then reads or writes 32-bit data through a window slot. A third bus slot is the end-of-interrupt (EOI) port.

Each input line can be edge or level sensitive, and active high or active low. The lines pass through a configurable synchronizer before they are sampled. Edge events on masked lines are thrown away. A level line that has been delivered stays in service until software writes its vector to the EOI slot. That write releases every level entry programmed with the same vector, so several level sources sharing one vector produce a single message per episode. Messages leave on a valid/ready port carrying vector, delivery mode and destination. Only one message is outstanding at a time. When several lines compete, the lowest-numbered line goes first.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: Bus slot 0 (`bus_addr`=0) holds an 8-bit register index written from `bus_wdata[7:0]` and read back in `bus_rdata[7:0]`. Slot 1 reads or writes the register that the index selects. Index 0x00 is an identity register whose bits 31:24 are writable and whose other bits read 0. Slots 2 and 3 read 0.
- R2: Index 0x01 is read-only. It returns the version parameter in bits 7:0 and the number of lines minus one in bits 23:16. All other bits read 0.
- R3: After reset, every entry's low word reads 0x0001_0000 (masked, all else zero), every high word reads 0, and no message is valid.
- R4: Entry n uses index 0x10+2n for its low word and 0x11+2n for its high word. Low word layout: vector 7:0, delivery mode 10:8, polarity 13 (1 = active low), in-service flag 14 (read-only), trigger 15 (1 = level), mask 16. High word layout: destination 31:16. All other bits read 0.
- R5: On an unmasked edge line, each inactive-to-active transition produces exactly one message carrying that entry's vector, mode and destination. A line that stays active produces no further messages.
- R6: An active edge seen while the line is masked is discarded. Unmasking the line later produces no message.
- R7: When a level line is delivered, it is marked in service (bit 14). While it is in service it produces no message. Writing its vector to bus slot 2 (`bus_wdata[7:0]`) clears the mark, and the line is delivered again if it is still active.
- R8: An EOI write clears the in-service mark only on level entries whose vector equals the written value, and it clears it on all of them.
- R9: When a level entry is delivered, every level entry with the same vector is marked in service. Sources sharing a vector therefore yield one message per episode.
- R10: Among requesting lines, the lowest-numbered line is sent first. A message stays valid with stable fields until `msg_ready` is high at a clock edge.
- R11: Indices that map to no register read 0, and writes to them change nothing.
- R12: With polarity 1, a line is active when low. A high-to-low input transition is then the edge that triggers delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_PINS | External interrupt lines |
| bus_wr | input | 1 | Write strobe for the addressed slot |
| bus_addr | input | 2 | Slot: 0 select, 1 data window, 2 EOI |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed slot (combinational) |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_dest | output | 16 | Message destination |

## Verification
The assertions assume that the bus never issues an EOI write for a vector in the same cycle that a level entry with that vector is being loaded. The stimulus keeps every EOI well apart from deliveries. The assertions also assume that `msg_ready` is only meaningful while a message is valid. The bench changes an entry's polarity only while that entry is masked, because an unmasked polarity flip is itself an edge. It also holds each input level for several cycles so that the synchronizer sees every transition.

// File: rtl/irq_redirect_pkg.sv
`timescale 1ns/1ps
package irq_redirect_pkg;

   // redirection entry low word bit positions
   localparam int LO_VEC_LSB  = 0;
   localparam int LO_MODE_LSB = 8;
   localparam int LO_POL_BIT  = 13;
   localparam int LO_SVC_BIT  = 14;
   localparam int LO_TRIG_BIT = 15;
   localparam int LO_MASK_BIT = 16;
   localparam int HI_DEST_LSB = 16;

   // register index map
   localparam logic [7:0] IDX_ID       = 8'h00;
   localparam logic [7:0] IDX_VER      = 8'h01;
   localparam logic [7:0] IDX_RTE_BASE = 8'h10;

   typedef enum logic [1:0] {
      SLOT_SEL = 2'd0,
      SLOT_WIN = 2'd1,
      SLOT_EOI = 2'd2,
      SLOT_RSV = 2'd3
   } bus_slot_e;

   typedef struct packed {
      logic [15:0] dest;
      logic        mask;
      logic        trig;
      logic        pol;
      logic [2:0]  mode;
      logic [7:0]  vec;
   } rte_t;

   localparam rte_t RTE_RESET = '{dest: 16'h0, mask: 1'b1, trig: 1'b0,
                                  pol: 1'b0, mode: 3'd0, vec: 8'h0};

endpackage

// File: rtl/irq_input_sync.sv
`timescale 1ns/1ps
module irq_input_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw,
   output logic [WIDTH-1:0] synced
);

   if (STAGES == 0) begin : g_bypass
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign synced = raw;
   end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
         end else begin
            stage_q[0] <= raw;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
         end
      end
      assign synced = stage_q[STAGES-1];
   end

endmodule

// File: rtl/irq_rte_bank.sv
`timescale 1ns/1ps
module irq_rte_bank
   import irq_redirect_pkg::*;
#(
   parameter int         NUM_PINS = 8,
   parameter logic [7:0] VERSION  = 8'h21
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [1:0]          bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_PINS-1:0] svc,
   output rte_t                rte [NUM_PINS],
   output logic                eoi_fire,
   output logic [7:0]          eoi_vec
);

   localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};

   logic [7:0] sel_q;
   logic [7:0] id_q;
   logic [7:0] rel;
   logic [6:0] ent_idx;
   logic       ent_hit;
   logic       win_wr;
   logic       unused_bits;

   assign rel     = sel_q - IDX_RTE_BASE;
   assign ent_idx = rel[7:1];
   assign ent_hit = (sel_q >= IDX_RTE_BASE) && (int'(ent_idx) < NUM_PINS);
   assign win_wr  = bus_wr && (bus_addr == SLOT_WIN);

   assign eoi_fire = bus_wr && (bus_addr == SLOT_EOI);
   assign eoi_vec  = bus_wdata[7:0];
   assign unused_bits = ^{bus_wdata[LO_SVC_BIT], bus_wdata[12:11]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         id_q  <= '0;
      end else begin
         if (bus_wr && bus_addr == SLOT_SEL) sel_q <= bus_wdata[7:0];
         if (win_wr && sel_q == IDX_ID)      id_q  <= bus_wdata[31:24];
      end
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_entry
      rte_t ent_q;
      logic hit_lo, hit_hi;
      assign hit_lo = win_wr && ent_hit && (int'(ent_idx) == i) && !sel_q[0];
      assign hit_hi = win_wr && ent_hit && (int'(ent_idx) == i) &&  sel_q[0];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q <= RTE_RESET;
         end else if (hit_hi) begin
            ent_q.dest <= bus_wdata[HI_DEST_LSB +: 16];
         end else if (hit_lo) begin
            ent_q.vec  <= bus_wdata[LO_VEC_LSB +: 8];
            ent_q.mode <= bus_wdata[LO_MODE_LSB +: 3];
            ent_q.pol  <= bus_wdata[LO_POL_BIT];
            ent_q.trig <= bus_wdata[LO_TRIG_BIT];
            ent_q.mask <= bus_wdata[LO_MASK_BIT];
         end
      end
      assign rte[i] = ent_q;
   end

   always_comb begin
      rte_t       pick;
      logic       pick_svc;
      logic [31:0] win;
      pick     = RTE_RESET;
      pick_svc = 1'b0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (int'(ent_idx) == i) begin
            pick     = rte[i];
            pick_svc = svc[i];
         end
      end
      win = '0;
      if (sel_q == IDX_ID) begin
         win[31:24] = id_q;
      end else if (sel_q == IDX_VER) begin
         win = VER_WORD;
      end else if (ent_hit) begin
         if (sel_q[0]) begin
            win[HI_DEST_LSB +: 16] = pick.dest;
         end else begin
            win[LO_VEC_LSB +: 8]  = pick.vec;
            win[LO_MODE_LSB +: 3] = pick.mode;
            win[LO_POL_BIT]       = pick.pol;
            win[LO_SVC_BIT]       = pick_svc;
            win[LO_TRIG_BIT]      = pick.trig;
            win[LO_MASK_BIT]      = pick.mask;
         end
      end
      case (bus_addr)
         SLOT_SEL: bus_rdata = {24'h0, sel_q};
         SLOT_WIN: bus_rdata = win;
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/irq_pin_track.sv
`timescale 1ns/1ps
module irq_pin_track (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_lvl,
   input  logic       pol,
   input  logic       trig,
   input  logic       mask,
   input  logic [7:0] vec,
   input  logic       load_hit,
   input  logic       load_level,
   input  logic [7:0] load_vec,
   input  logic       eoi_fire,
   input  logic [7:0] eoi_vec,
   output logic       req,
   output logic       svc
);

   logic act, prev_q, pend_q, svc_q, edge_seen;

   assign act       = pin_lvl ^ pol;
   assign edge_seen = act & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
         svc_q  <= 1'b0;
      end else begin
         prev_q <= act;
         // edge latch: masked or level entries hold nothing
         if (mask || trig)   pend_q <= 1'b0;
         else if (edge_seen) pend_q <= 1'b1;
         else if (load_hit)  pend_q <= 1'b0;
         // in-service mark: a delivery of the shared vector wins over EOI
         if (!trig)                                svc_q <= 1'b0;
         else if (load_level && vec == load_vec)   svc_q <= 1'b1;
         else if (eoi_fire && vec == eoi_vec)      svc_q <= 1'b0;
      end
   end

   assign req = ~mask & (trig ? (act & ~svc_q) : pend_q);
   assign svc = svc_q;

endmodule

// File: rtl/irq_msg_arbiter.sv
`timescale 1ns/1ps
module irq_msg_arbiter #(
   parameter int NUM_PINS = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_PINS-1:0]       req,
   input  logic [NUM_PINS-1:0][7:0]  ent_vec,
   input  logic [NUM_PINS-1:0][2:0]  ent_mode,
   input  logic [NUM_PINS-1:0][15:0] ent_dest,
   input  logic [NUM_PINS-1:0]       ent_trig,
   output logic [NUM_PINS-1:0]       load_hit,
   output logic                      load_level,
   output logic [7:0]                load_vec,
   output logic                      msg_valid,
   input  logic                      msg_ready,
   output logic [7:0]                msg_vector,
   output logic [2:0]                msg_mode,
   output logic [15:0]               msg_dest
);

   localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

   logic [IDX_W-1:0] pick;
   logic             any;
   logic             load;

   always_comb begin
      pick = '0;
      any  = 1'b0;
      for (int i = NUM_PINS - 1; i >= 0; i--) begin
         if (req[i]) begin
            pick = IDX_W'(i);
            any  = 1'b1;
         end
      end
   end

   assign load       = any & ~msg_valid;
   assign load_level = load & ent_trig[pick];
   assign load_vec   = ent_vec[pick];

   always_comb begin
      for (int i = 0; i < NUM_PINS; i++) load_hit[i] = load && (pick == IDX_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid  <= 1'b0;
         msg_vector <= '0;
         msg_mode   <= '0;
         msg_dest   <= '0;
      end else if (msg_valid && msg_ready) begin
         msg_valid <= 1'b0;
      end else if (load) begin
         msg_valid  <= 1'b1;
         msg_vector <= ent_vec[pick];
         msg_mode   <= ent_mode[pick];
         msg_dest   <= ent_dest[pick];
      end
   end

endmodule

// File: rtl/irq_redirect_ctrl.sv
`timescale 1ns/1ps
module irq_redirect_ctrl
   import irq_redirect_pkg::*;
#(
   parameter int         NUM_PINS    = 8,
   parameter logic [7:0] VERSION     = 8'h21,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] irq_in,
   input  logic                bus_wr,
   input  logic [1:0]          bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic                msg_valid,
   input  logic                msg_ready,
   output logic [7:0]          msg_vector,
   output logic [2:0]          msg_mode,
   output logic [15:0]         msg_dest
);

   if (NUM_PINS < 1 || NUM_PINS > 120) begin : g_bad_pins
      $error("NUM_PINS must lie in 1..120 to fit the index map");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 0..4");
   end

   logic [NUM_PINS-1:0]       pin_lvl;
   logic [NUM_PINS-1:0]       pin_req;
   logic [NUM_PINS-1:0]       pin_svc;
   logic [NUM_PINS-1:0]       pin_trig;
   logic [NUM_PINS-1:0][7:0]  pin_vec;
   logic [NUM_PINS-1:0][2:0]  pin_mode;
   logic [NUM_PINS-1:0][15:0] pin_dest;
   logic [NUM_PINS-1:0]       load_hit;
   logic                      load_level;
   logic [7:0]                load_vec;
   logic                      eoi_fire;
   logic [7:0]                eoi_vec;
   rte_t                      rte [NUM_PINS];

   irq_input_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw(irq_in), .synced(pin_lvl)
   );

   irq_rte_bank #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .svc(pin_svc),
      .rte(rte), .eoi_fire(eoi_fire), .eoi_vec(eoi_vec)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      assign pin_trig[i] = rte[i].trig;
      assign pin_vec[i]  = rte[i].vec;
      assign pin_mode[i] = rte[i].mode;
      assign pin_dest[i] = rte[i].dest;
      irq_pin_track u_track (
         .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl[i]),
         .pol(rte[i].pol), .trig(rte[i].trig), .mask(rte[i].mask),
         .vec(rte[i].vec), .load_hit(load_hit[i]), .load_level(load_level),
         .load_vec(load_vec), .eoi_fire(eoi_fire), .eoi_vec(eoi_vec),
         .req(pin_req[i]), .svc(pin_svc[i])
      );
   end

   irq_msg_arbiter #(.NUM_PINS(NUM_PINS)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(pin_req), .ent_vec(pin_vec),
      .ent_mode(pin_mode), .ent_dest(pin_dest), .ent_trig(pin_trig),
      .load_hit(load_hit), .load_level(load_level), .load_vec(load_vec),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
      .msg_mode(msg_mode), .msg_dest(msg_dest)
   );

endmodule

// File: rtl/irq_redirect_ctrl_chk.sv
`timescale 1ns/1ps
module irq_redirect_ctrl_chk #(
   parameter int NUM_PINS = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      bus_wr,
   input logic [1:0]                bus_addr,
   input logic [31:0]               bus_wdata,
   input logic [31:0]               bus_rdata,
   input logic                      msg_valid,
   input logic                      msg_ready,
   input logic [7:0]                msg_vector,
   input logic [2:0]                msg_mode,
   input logic [15:0]               msg_dest,
   input logic [NUM_PINS-1:0]       pin_svc,
   input logic [NUM_PINS-1:0]       pin_trig,
   input logic [NUM_PINS-1:0][7:0]  pin_vec
);

   assert_select_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd0) |=> (bus_addr != 2'd0 || bus_rdata[7:0] == $past(bus_wdata[7:0])));

   assert_idle_after_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !msg_valid);

   assert_hold_until_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_mode) && $stable(msg_dest)));

   assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready) |=> !msg_valid);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
      assert_in_service_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (pin_svc[i] && pin_trig[i] && !(bus_wr && bus_addr == 2'd2 && bus_wdata[7:0] == pin_vec[i]))
         |=> pin_svc[i]);
   end

endmodule

bind irq_redirect_ctrl irq_redirect_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msg_valid(msg_valid),
   .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_mode(msg_mode),
   .msg_dest(msg_dest), .pin_svc(pin_svc), .pin_trig(pin_trig), .pin_vec(pin_vec)
);

// File: tb/irq_redirect_ctrl_tb.sv
`timescale 1ns/1ps
module irq_redirect_ctrl_tb;

   localparam int N = 8;
   localparam int S = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] irq_in = '0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        msg_valid;
   logic        msg_ready = 1'b0;
   logic [7:0]  msg_vector;
   logic [2:0]  msg_mode;
   logic [15:0] msg_dest;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   irq_redirect_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
      .msg_mode(msg_mode), .msg_dest(msg_dest)
   );

   // ---------------- reference model ----------------
   int m_sel, m_id, m_mvec, m_mmode, m_mdest;
   int m_vec [N], m_mode [N], m_pol [N], m_trig [N], m_mask [N], m_dest [N];
   bit m_svc [N], m_pend [N], m_prev [N];
   bit m_valid;
   logic [N-1:0] m_sh [S];

   task automatic model_reset();
      m_sel = 0; m_id = 0; m_valid = 0; m_mvec = 0; m_mmode = 0; m_mdest = 0;
      for (int i = 0; i < N; i++) begin
         m_vec[i] = 0; m_mode[i] = 0; m_pol[i] = 0; m_trig[i] = 0;
         m_mask[i] = 1; m_dest[i] = 0; m_svc[i] = 0; m_pend[i] = 0; m_prev[i] = 0;
      end
      for (int s = 0; s < S; s++) m_sh[s] = '0;
   endtask

   task automatic model_step();
      bit act [N];
      bit req [N];
      bit np [N];
      bit nr [N];
      int k;
      bit load;
      bit eoi;
      int idx;
      k = -1;
      for (int i = 0; i < N; i++) begin
         act[i] = m_sh[S-1][i] ^ m_pol[i][0];
         req[i] = !m_mask[i] && (m_trig[i] != 0 ? (act[i] && !m_svc[i]) : m_pend[i]);
      end
      for (int i = N - 1; i >= 0; i--) if (req[i]) k = i;
      load = (k >= 0) && !m_valid;
      eoi = bus_wr && bus_addr == 2'd2;
      for (int i = 0; i < N; i++) begin
         if (m_mask[i] != 0 || m_trig[i] != 0) np[i] = 0;
         else if (act[i] && !m_prev[i]) np[i] = 1;
         else if (load && k == i) np[i] = 0;
         else np[i] = m_pend[i];
         if (m_trig[i] == 0) nr[i] = 0;
         else if (load && m_trig[k] != 0 && m_vec[i] == m_vec[k]) nr[i] = 1;
         else if (eoi && m_vec[i] == int'(bus_wdata[7:0])) nr[i] = 0;
         else nr[i] = m_svc[i];
      end
      if (m_valid && msg_ready) m_valid = 0;
      else if (load) begin
         m_valid = 1; m_mvec = m_vec[k]; m_mmode = m_mode[k]; m_mdest = m_dest[k];
      end
      for (int i = 0; i < N; i++) begin
         m_pend[i] = np[i]; m_svc[i] = nr[i]; m_prev[i] = act[i];
      end
      if (bus_wr && bus_addr == 2'd0) m_sel = int'(bus_wdata[7:0]);
      else if (bus_wr && bus_addr == 2'd1) begin
         if (m_sel == 0) m_id = int'(bus_wdata[31:24]);
         else if (m_sel >= 16 && (m_sel - 16) / 2 < N) begin
            idx = (m_sel - 16) / 2;
            if (m_sel % 2 == 1) m_dest[idx] = int'(bus_wdata[31:16]);
            else begin
               m_vec[idx] = int'(bus_wdata[7:0]); m_mode[idx] = int'(bus_wdata[10:8]);
               m_pol[idx] = int'(bus_wdata[13]); m_trig[idx] = int'(bus_wdata[15]);
               m_mask[idx] = int'(bus_wdata[16]);
            end
         end
      end
      for (int s = S - 1; s > 0; s--) m_sh[s] = m_sh[s-1];
      m_sh[0] = irq_in;
   endtask

   function automatic logic [31:0] model_rdata();
      int idx;
      logic [31:0] r;
      r = '0;
      if (bus_addr == 2'd0) r = 32'(m_sel);
      else if (bus_addr == 2'd1) begin
         if (m_sel == 0) r = 32'(m_id) << 24;
         else if (m_sel == 1) r = {8'h00, 8'(N - 1), 8'h00, 8'h21};
         else if (m_sel >= 16 && (m_sel - 16) / 2 < N) begin
            idx = (m_sel - 16) / 2;
            if (m_sel % 2 == 1) r = 32'(m_dest[idx]) << 16;
            else r = (32'(m_mask[idx]) << 16) | (32'(m_trig[idx]) << 15) |
                     (32'(m_svc[idx]) << 14) | (32'(m_pol[idx]) << 13) |
                     (32'(m_mode[idx]) << 8) | 32'(m_vec[idx]);
         end
      end
      return r;
   endfunction

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else model_step();
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always begin
      @(posedge clk);
      #3;
      if (rst_n && !done) begin
         chk("R10 model msg_valid", 32'(msg_valid), 32'(m_valid));
         if (m_valid) begin
            chk("R5 model msg_vector", 32'(msg_vector), 32'(m_mvec));
            chk("R5 model msg_mode", 32'(msg_mode), 32'(m_mmode));
            chk("R5 model msg_dest", 32'(msg_dest), 32'(m_mdest));
         end
         chk("R1 model bus_rdata", bus_rdata, model_rdata());
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wreg(logic [7:0] idx, logic [31:0] d);
      wr(2'd0, {24'h0, idx});
      wr(2'd1, d);
   endtask

   task automatic rreg(logic [7:0] idx, output logic [31:0] d);
      wr(2'd0, {24'h0, idx});
      rd(2'd1, d);
   endtask

   task automatic wait_msg(string tag, logic [7:0] vec);
      bit got;
      got = 0;
      for (int c = 0; c < 20 && !got; c++) begin
         @(negedge clk);
         if (msg_valid) got = 1;
      end
      chk({tag, " message arrives"}, 32'(got), 32'd1);
      if (got) chk({tag, " vector"}, 32'(msg_vector), 32'(vec));
   endtask

   task automatic take();
      msg_ready = 1'b1;
      @(negedge clk);
      msg_ready = 1'b0;
   endtask

   task automatic quiet(string tag, int n);
      int seen;
      seen = 0;
      for (int c = 0; c < n; c++) begin
         @(negedge clk);
         if (msg_valid) seen++;
      end
      chk({tag, " no message"}, 32'(seen), 32'd0);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL R10 watchdog expired actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      idle(3);
      // R3: reset state
      chk("R3 msg_valid in reset", 32'(msg_valid), 32'd0);
      @(negedge clk) rst_n = 1'b1;
      rreg(8'h10, d); chk("R3 entry0 low", d, 32'h0001_0000);
      rreg(8'h11, d); chk("R3 entry0 high", d, 32'h0);
      rreg(8'h1E, d); chk("R3 last entry low", d, 32'h0001_0000);
      // R2: version layout
      rreg(8'h01, d); chk("R2 version", d, 32'h0007_0021);
      // R1: select readback and identity register
      wr(2'd0, 32'h0000_0037); rd(2'd0, d); chk("R1 select readback", d, 32'h37);
      wreg(8'h00, 32'hFFFF_FFFF); rd(2'd1, d); chk("R1 identity", d, 32'hFF00_0000);
      rd(2'd2, d); chk("R1 slot2 reads zero", d, 32'h0);
      // R11: unmapped indices
      wreg(8'h05, 32'hDEAD_BEEF); rd(2'd1, d); chk("R11 unmapped index", d, 32'h0);
      wreg(8'h20, 32'hFFFF_FFFF); rd(2'd1, d); chk("R11 beyond last entry", d, 32'h0);
      rreg(8'h10, d); chk("R11 entry0 untouched", d, 32'h0001_0000);
      // R4: field positions, read-only in-service bit
      wreg(8'h17, 32'hFFFF_FFFF); rd(2'd1, d); chk("R4 high word", d, 32'hFFFF_0000);
      wreg(8'h16, 32'hFFFF_FFFF); rd(2'd1, d); chk("R4 low word", d, 32'h0001_A7FF);
      wreg(8'h16, 32'h0001_0000);
      // R5: edge delivery with fields
      wreg(8'h15, 32'h1234_0000);
      wreg(8'h14, 32'h0000_0140);
      @(negedge clk) irq_in[2] = 1'b1;
      wait_msg("R5 edge", 8'h40);
      chk("R5 mode", 32'(msg_mode), 32'd1);
      chk("R5 dest", 32'(msg_dest), 32'h1234);
      idle(3);
      chk("R10 held while not ready", 32'(msg_valid), 32'd1);
      take();
      quiet("R5 steady high", 10);
      @(negedge clk) irq_in[2] = 1'b0;
      idle(4);
      // R6: masked edge dropped
      wreg(8'h14, 32'h0001_0140);
      @(negedge clk) irq_in[2] = 1'b1;
      idle(8);
      wreg(8'h14, 32'h0000_0140);
      quiet("R6 after unmask", 10);
      @(negedge clk) irq_in[2] = 1'b0;
      idle(4);
      // R12: active-low polarity
      wreg(8'h14, 32'h0001_2140);
      idle(4);
      wreg(8'h14, 32'h0000_2140);
      quiet("R12 no edge on unmask", 6);
      @(negedge clk) irq_in[2] = 1'b1;
      quiet("R12 rising is inactive", 6);
      @(negedge clk) irq_in[2] = 1'b0;
      wait_msg("R12 falling edge", 8'h40);
      take();
      wreg(8'h14, 32'h0001_2140);
      // R7: level in-service and EOI
      @(negedge clk) irq_in[4] = 1'b1;
      idle(4);
      wreg(8'h18, 32'h0000_8055);
      wait_msg("R7 level", 8'h55);
      take();
      rreg(8'h18, d); chk("R7 in-service set", d, 32'h0000_C055);
      quiet("R7 while in service", 10);
      wr(2'd2, 32'h56);
      rreg(8'h18, d); chk("R8 other vector keeps mark", d, 32'h0000_C055);
      quiet("R8 wrong EOI", 6);
      wr(2'd2, 32'h55);
      wait_msg("R7 redelivery after EOI", 8'h55);
      take();
      @(negedge clk) irq_in[4] = 1'b0;
      idle(4);
      wr(2'd2, 32'h55);
      rreg(8'h18, d); chk("R7 mark cleared", d, 32'h0000_8055);
      quiet("R7 inactive after EOI", 6);
      wreg(8'h18, 32'h0001_8055);
      // R9 / R8: shared vector
      wreg(8'h1A, 32'h0001_8060);
      wreg(8'h1C, 32'h0001_8060);
      @(negedge clk) irq_in[6:5] = 2'b11;
      idle(4);
      wreg(8'h1A, 32'h0000_8060);
      wait_msg("R9 shared first", 8'h60);
      take();
      wreg(8'h1C, 32'h0000_8060);
      quiet("R9 sharer suppressed", 12);
      rreg(8'h1C, d); chk("R9 sharer in service", d, 32'h0000_C060);
      wr(2'd2, 32'h60);
      wait_msg("R9 one per episode", 8'h60);
      take();
      quiet("R9 single message", 10);
      @(negedge clk) irq_in[6:5] = 2'b00;
      idle(4);
      wr(2'd2, 32'h60);
      rreg(8'h1A, d); chk("R8 released entry5", d, 32'h0000_8060);
      rreg(8'h1C, d); chk("R8 released entry6", d, 32'h0000_8060);
      // R10: priority
      wreg(8'h10, 32'h0000_0010);
      wreg(8'h12, 32'h0000_0011);
      @(negedge clk) irq_in[1:0] = 2'b11;
      wait_msg("R10 lowest first", 8'h10);
      take();
      wait_msg("R10 second", 8'h11);
      take();
      quiet("R10 drained", 8);
      @(negedge clk) irq_in[1:0] = 2'b00;
      idle(4);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule